// File: doc/BRIEF.md
# Oversampled Start-Bit Verifier

This block sits at the front of an asynchronous serial receiver. It watches the raw line with a receive clock that runs N times faster than the bit rate, where N is 8, 16, 32 or 64. It finds the leading edge of each character and confirms that edge with a second look near the middle of the start bit. It then places one sample near the centre of every bit that follows. A low pulse that has already ended by the confirmation point counts as line noise, and the block goes back to searching.

The serial input first passes through a two-flop synchronizer. A falling transition on the synchronized line starts a half-bit wait. If the line is still low after that wait, the character is accepted. The block then takes one sample every N clocks for the data bits, the optional parity bit and one or two stop bits, and goes back to the search state after the last of them. Each character starts a fresh timing reference, so clock drift does not build up from one character to the next. Assembling the data word and raising framing or parity errors belong to a later stage.

The sample output is a one-way stream. `samp_valid` is a single-cycle strobe, and `samp_bit` is valid only in that cycle. The block has no ready input: a serial line cannot be stalled, so the consumer must accept every strobe. The configuration pins are plain levels.

Top module: `rx_start_verifier`

## Requirements
- R1: After reset, `samp_valid` and `char_active` are low and the block is searching for a start edge.
- R2: `ratio_sel` sets the oversampling ratio: 2'b00 = 8x, 2'b01 = 16x, 2'b10 = 32x, 2'b11 = 64x. The confirmation sample is taken N/2 receive clocks after the clock that detects the edge, which leaves N/2-1 clocks of waiting in between. Later samples are spaced N clocks apart.
- R3: `rx_serial` passes through two synchronizer flops before edge detection. A fall that is set up before rising edge E1 is detected at edge E3.
- R4: If the confirmation sample is high, the edge is dropped as noise. No strobe is produced, `char_active` stays low, and searching resumes. An input low of N/2 clocks is rejected. An input low of N/2+1 clocks is accepted as a start bit.
- R5: Each accepted character produces exactly `data_bits` + `parity_en` + (`two_stop` ? 2 : 1) strobes. The legal range of `data_bits` is 5 to 9.
- R6: The first strobe follows the detecting edge by N/2 + N clocks. Each strobe lasts one cycle, and `samp_bit` carries the synchronized line value sampled at that point, so the data bits appear LSB first.
- R7: `char_active` rises one cycle after the confirming edge. It falls in the same cycle as the last strobe of the character.
- R8: `ratio_sel` is captured when the edge is detected, and `data_bits`, `parity_en` and `two_stop` are captured at confirmation. Changes to these pins during a character have no effect on that character.
- R9: After the last sample, a new falling edge starts a new character. Its timing is measured from the new edge alone, so back-to-back characters are each sampled correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, N times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_serial | input | 1 | Raw serial line, idles high |
| ratio_sel | input | 2 | Oversampling ratio code |
| data_bits | input | 4 | Number of data bits per character (5 to 9) |
| parity_en | input | 1 | Adds one parity bit sample |
| two_stop | input | 1 | Two stop bit samples instead of one |
| samp_valid | output | 1 | One-cycle sample strobe |
| samp_bit | output | 1 | Sampled bit value, valid with samp_valid |
| char_active | output | 1 | High while a confirmed character is being sampled |

## Verification
A wrong phase in the down-counter moves every strobe of a character by the same number of clocks. The first strobe after the confirmation point already lands on the wrong clock, so checks against exact cycle numbers catch the error on the first bit. A wrong count of remaining bits shows at the end of the character: `char_active` drops early or late, and the strobe count is off. A broken noise decision shows up as early as the edge itself, as strobes or a `char_active` pulse after a short low pulse, or as a missing character after a low that lasts one clock longer. A synchronizer stage that is missing or extra shifts the whole schedule by one clock.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  // Smallest supported ratio is 2**RATIO_LOG_MIN (8x); ratio_sel adds to it.
  localparam int RATIO_LOG_MIN = 3;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_BITS    = 2'd2
  } rsv_state_e;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rsv_pacer.sv
module rsv_pacer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R2
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/rsv_seq.sv
module rsv_seq
  import rsv_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int DB_W  = 4,
  parameter int TOT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_s,
  input  logic [1:0]       ratio_sel,
  input  logic [DB_W-1:0]  data_bits,
  input  logic             parity_en,
  input  logic             two_stop,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             samp_valid,
  output logic             samp_bit,
  output logic             char_active
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  rsv_state_e       state;
  logic             line_prev;
  logic [1:0]       sel_lat;
  logic [TOT_W-1:0] left;
  logic [TOT_W-1:0] total_lat;
  logic             fall;
  logic [TOT_W-1:0] total_cfg;
  logic [CNT_W-1:0] half_m1;
  logic [CNT_W-1:0] span_m1;

  assign fall      = line_prev & ~line_s;
  assign total_cfg = TOT_W'(data_bits) + TOT_W'(parity_en) + TOT_W'(1) + TOT_W'(two_stop);
  assign half_m1   = (ONE << (RATIO_LOG_MIN - 1 + int'(ratio_sel))) - ONE;
  assign span_m1   = (ONE << (RATIO_LOG_MIN + int'(sel_lat))) - ONE;

  always_comb begin
    load     = 1'b0;
    load_val = half_m1;
    case (state)
      ST_HUNT:    load = fall;
      ST_CONFIRM: begin
        load     = expired && !line_s;
        load_val = span_m1;
      end
      ST_BITS:    begin
        load     = expired && (left != TOT_W'(1));
        load_val = span_m1;
      end
      default:    load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      line_prev  <= 1'b1;
      sel_lat    <= 2'd0;
      left       <= '0;
      total_lat  <= '0;
      samp_valid <= 1'b0;
      samp_bit   <= 1'b1;
    end else begin
      line_prev  <= line_s;
      samp_valid <= 1'b0;
      case (state)
        ST_HUNT: if (fall) begin
          sel_lat <= ratio_sel;
          state   <= ST_CONFIRM;
        end
        ST_CONFIRM: if (expired) begin
          if (!line_s) begin
            state     <= ST_BITS;
            left      <= total_cfg;
            total_lat <= total_cfg;
          end else begin
            state <= ST_HUNT;
          end
        end
        ST_BITS: if (expired) begin
          samp_valid <= 1'b1;
          samp_bit   <= line_s;
          if (left == TOT_W'(1)) state <= ST_HUNT;
          else                   left  <= left - 1'b1;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign char_active = (state == ST_BITS);

  // Strobe tally used only by the count check below.
  logic [TOT_W-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        chk_cnt <= '0;
    else if (samp_valid && !char_active) chk_cnt <= '0;
    else if (samp_valid)               chk_cnt <= chk_cnt + 1'b1;
  end

  // R5
  strobe_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && !char_active) |-> (chk_cnt + TOT_W'(1) == total_lat));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |=> !samp_valid);

  // R4
  confirm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_active) |-> !$past(line_s));

  // R7
  strobe_in_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |-> $past(char_active));
endmodule

// File: rtl/rx_start_verifier.sv
module rx_start_verifier #(
  parameter int MAX_DATA      = 9,
  parameter int MAX_RATIO_LOG = 6,
  parameter int SYNC_STAGES   = 2,
  localparam int DB_W  = $clog2(MAX_DATA + 1),
  localparam int TOT_W = $clog2(MAX_DATA + 4),
  localparam int CNT_W = MAX_RATIO_LOG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_serial,
  input  logic [1:0]      ratio_sel,
  input  logic [DB_W-1:0] data_bits,
  input  logic            parity_en,
  input  logic            two_stop,
  output logic            samp_valid,
  output logic            samp_bit,
  output logic            char_active
);
  logic             line_s;
  logic             expired;
  logic             load;
  logic [CNT_W-1:0] load_val;

  rsv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rx_serial),
    .d_out (line_s)
  );

  rsv_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  rsv_seq #(.CNT_W(CNT_W), .DB_W(DB_W), .TOT_W(TOT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_s      (line_s),
    .ratio_sel   (ratio_sel),
    .data_bits   (data_bits),
    .parity_en   (parity_en),
    .two_stop    (two_stop),
    .expired     (expired),
    .load        (load),
    .load_val    (load_val),
    .samp_valid  (samp_valid),
    .samp_bit    (samp_bit),
    .char_active (char_active)
  );
endmodule

// File: tb/rx_start_verifier_bench.sv
module rx_start_verifier_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_serial = 1'b1;
  logic [1:0] ratio_sel = 2'd1;
  logic [3:0] data_bits = 4'd8;
  logic       parity_en = 1'b0;
  logic       two_stop = 1'b0;
  logic       samp_valid;
  logic       samp_bit;
  logic       char_active;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int n_got = 0;
  int got_cyc [64];
  logic got_bit [64];
  logic ca_prev = 1'b0;
  logic ca_seen = 1'b0;
  int ca_rise = -1;
  int ca_fall = -1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_start_verifier u_rx_start_verifier (
    .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial), .ratio_sel(ratio_sel),
    .data_bits(data_bits), .parity_en(parity_en), .two_stop(two_stop),
    .samp_valid(samp_valid), .samp_bit(samp_bit), .char_active(char_active)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (samp_valid && n_got < 64) begin
      got_cyc[n_got] = cyc;
      got_bit[n_got] = samp_bit;
      n_got = n_got + 1;
    end
    if (char_active && !ca_prev) ca_rise = cyc;
    if (!char_active && ca_prev) ca_fall = cyc;
    if (char_active) ca_seen = 1'b1;
    ca_prev = char_active;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] sel);
    return 8 << sel;
  endfunction

  function automatic logic [15:0] build(input logic [8:0] data, input int db,
                                        input bit par, input bit st2, output int cnt);
    logic [15:0] b = '1;
    logic p = 1'b0;
    for (int k = 0; k < db; k++) begin
      b[k] = data[k];
      p = p ^ data[k];
    end
    cnt = db;
    if (par) begin b[cnt] = p; cnt++; end
    b[cnt] = 1'b1; cnt++;
    if (st2) begin b[cnt] = 1'b1; cnt++; end
    return b;
  endfunction

  task automatic drive_frame(input int n, input logic [15:0] bits, input int cnt, output int t0);
    @(negedge clk);
    t0 = cyc;
    rx_serial = 1'b0;
    repeat (n) @(negedge clk);
    for (int k = 0; k < cnt; k++) begin
      rx_serial = bits[k];
      repeat (n) @(negedge clk);
    end
  endtask

  task automatic check_samples(input int base, input int t0, input int n,
                               input logic [15:0] bits, input int cnt, input string req);
    for (int k = 0; k < cnt; k++) begin
      if (base + k < n_got) begin
        chk(got_bit[base+k] == bits[k], {req, " bit value"}, got_bit[base+k], bits[k]);
        chk(got_cyc[base+k] == t0 + 3 + n/2 + n*(k+1), {req, " strobe cycle"},
            got_cyc[base+k], t0 + 3 + n/2 + n*(k+1));
      end
    end
  endtask

  // R2 R3 R5 R6: one full character at a given ratio and format
  task automatic t_frame(input logic [1:0] sel, input int db, input bit par, input bit st2,
                         input logic [8:0] data, input string req);
    int cnt, t0, n;
    logic [15:0] bits;
    n = ratio_of(sel);
    ratio_sel = sel; data_bits = 4'(db); parity_en = par; two_stop = st2;
    bits = build(data, db, par, st2, cnt);
    n_got = 0;
    drive_frame(n, bits, cnt, t0);
    repeat (2*n) @(negedge clk);
    chk(n_got == cnt, {req, " strobe count"}, n_got, cnt);
    check_samples(0, t0, n, bits, cnt, req);
  endtask

  // R4: low pulse of len clocks at the input
  task automatic t_noise(input logic [1:0] sel, input int len, input bit accept);
    int n, t0, cnt;
    logic [15:0] bits;
    n = ratio_of(sel);
    ratio_sel = sel; data_bits = 4'd8; parity_en = 1'b0; two_stop = 1'b0;
    bits = build(9'h1FF, 8, 1'b0, 1'b0, cnt);
    n_got = 0; ca_seen = 1'b0;
    @(negedge clk);
    t0 = cyc;
    rx_serial = 1'b0;
    repeat (len) @(negedge clk);
    rx_serial = 1'b1;
    repeat (n*(cnt+3)) @(negedge clk);
    if (accept) begin
      chk(n_got == cnt, "R4 boundary accepted strobe count", n_got, cnt);
      check_samples(0, t0, n, bits, cnt, "R4 boundary accepted");
    end else begin
      chk(n_got == 0, "R4 noise gives no strobe", n_got, 0);
      chk(ca_seen == 1'b0, "R4 noise leaves char_active low", ca_seen, 0);
    end
  endtask

  // R8: configuration pins change mid-character
  task automatic t_disturb();
    int cnt, t0, n;
    logic [15:0] bits;
    n = 16;
    ratio_sel = 2'd1; data_bits = 4'd8; parity_en = 1'b0; two_stop = 1'b0;
    bits = build(9'h0C3, 8, 1'b0, 1'b0, cnt);
    n_got = 0;
    fork
      drive_frame(n, bits, cnt, t0);
      begin
        repeat (4) @(negedge clk);
        ratio_sel = 2'd3;
        repeat (20) @(negedge clk);
        data_bits = 4'd5; parity_en = 1'b1; two_stop = 1'b1;
      end
    join
    repeat (2*n) @(negedge clk);
    chk(n_got == cnt, "R8 latched format strobe count", n_got, cnt);
    check_samples(0, t0, n, bits, cnt, "R8 latched ratio");
  endtask

  // R7: char_active window
  task automatic t_active();
    int cnt, t0, n;
    logic [15:0] bits;
    n = 8;
    ratio_sel = 2'd0; data_bits = 4'd6; parity_en = 1'b1; two_stop = 1'b0;
    bits = build(9'h2D, 6, 1'b1, 1'b0, cnt);
    n_got = 0; ca_rise = -1; ca_fall = -1;
    drive_frame(n, bits, cnt, t0);
    repeat (2*n) @(negedge clk);
    chk(ca_rise == t0 + 3 + n/2, "R7 char_active rise", ca_rise, t0 + 3 + n/2);
    chk(ca_fall == t0 + 3 + n/2 + n*cnt, "R7 char_active fall", ca_fall, t0 + 3 + n/2 + n*cnt);
  endtask

  // R9: two characters back to back
  task automatic t_b2b();
    int c1, c2, ta, tb, n;
    logic [15:0] b1, b2;
    n = 16;
    ratio_sel = 2'd1; data_bits = 4'd8; parity_en = 1'b0; two_stop = 1'b0;
    b1 = build(9'h3C, 8, 1'b0, 1'b0, c1);
    b2 = build(9'h81, 8, 1'b0, 1'b0, c2);
    n_got = 0;
    drive_frame(n, b1, c1, ta);
    drive_frame(n, b2, c2, tb);
    repeat (2*n) @(negedge clk);
    chk(n_got == c1 + c2, "R9 back-to-back strobe count", n_got, c1 + c2);
    check_samples(0, ta, n, b1, c1, "R9 first char");
    check_samples(c1, tb, n, b2, c2, "R9 second char");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(samp_valid == 1'b0, "R1 samp_valid in reset", samp_valid, 0);
    chk(char_active == 1'b0, "R1 char_active in reset", char_active, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(samp_valid == 1'b0 && char_active == 1'b0, "R1 idle after reset", samp_valid, 0);
    t_frame(2'd1, 8, 1'b0, 1'b0, 9'h0A5, "R2 R6 16x 8N1");
    t_frame(2'd0, 7, 1'b1, 1'b1, 9'h05A, "R5 8x 7E2");
    t_frame(2'd2, 5, 1'b0, 1'b0, 9'h013, "R2 32x 5N1");
    t_frame(2'd3, 9, 1'b1, 1'b0, 9'h1C3, "R5 64x 9 bits parity");
    t_noise(2'd1, 8, 1'b0);
    t_noise(2'd1, 9, 1'b1);
    t_noise(2'd0, 4, 1'b0);
    t_noise(2'd3, 32, 1'b0);
    t_disturb();
    t_active();
    t_b2b();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule